// File: doc/BRIEF.md
# Memory Fence Completion Tracker

This block sits between the decode stage of a weakly ordered core and its memory port. Memory operations arrive in program order at one request port, each marked either as a data access or as a fence. Data accesses are granted freely, and a single counter records how many of them are still in flight in the memory system. The memory system sends one completion pulse per finished data access, and each pulse lowers the counter.

A fence is held at the request port until the in-flight count reaches zero. Because the port is in order, nothing behind the fence can issue while it waits. Fences therefore retire in program order, and each one marks a point where all older data accesses are done. The ordering of data accesses between two fences is left to the memory system. The counter width is a parameter. When the counter is full, new data accesses are stalled so that the count cannot wrap.

Top module: `fence_tracker`

## Requirements
- R1: After reset the in-flight count is zero. With no request present, `issueGrant` and `stall` are both low. A fence presented first after reset is granted in that same cycle.
- R2: A data request (`reqFence`=0) is granted in the cycle it is presented when the in-flight count is below its maximum of 2^CNT_W-1. Each such grant raises the count by one at the next clock edge.
- R3: Each cycle with `cmplPulse` high lowers the in-flight count by one at the next clock edge. A completion pulse is legal only while the count is nonzero.
- R4: A fence request (`reqFence`=1) is not granted, and `stall` is high, in every cycle in which the in-flight count is nonzero.
- R5: A fence is granted in the first cycle in which the in-flight count reads zero. Because a fence cannot be granted in the same cycle as a data request, no data issue is pending in that cycle.
- R6: While a fence waits, no memory operation is granted. The data request that follows a granted fence is granted in the next cycle if the count allows it.
- R7: A data grant and a completion pulse in the same cycle leave the in-flight count unchanged.
- R8: When the count equals 2^CNT_W-1, a data request is stalled (`issueGrant`=0, `stall`=1). The count never wraps.
- R9: Fences presented back to back while the count is zero are granted one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A memory operation is presented at the head of the stream |
| reqFence | input | 1 | 1: the presented operation is a fence; 0: it is a data access |
| cmplPulse | input | 1 | One-cycle pulse: one in-flight data access has completed |
| issueGrant | output | 1 | The presented operation issues (data) or retires (fence) this cycle |
| stall | output | 1 | An operation is presented but held this cycle |

## Verification
The bench builds the tracker with CNT_W=2, so the counter is full after three accesses. This lets the saturation stall and its release by one completion be reached in a few cycles. The small width also makes the exact count visible at the ports. The bench measures how many completions a waiting fence needs before it is granted, and this exposes an off-by-one from a wrong simultaneous update or a wrap.

// File: rtl/mfence_pkg.sv
package mfence_pkg;
  // Strobes from the grant control to the outstanding counter
  typedef struct packed {
    logic incr;  // one data access issued
    logic decr;  // one data access completed
  } ctrStrobe_t;
endpackage

// File: rtl/mfence_ctr.sv
module mfence_ctr
  import mfence_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrStrobe_t       stb,
  output logic [CNT_W-1:0] count,
  output logic             cntZero,
  output logic             cntFull
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CntOne = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({stb.incr, stb.decr})
        2'b10:   count <= count + CntOne;
        2'b01:   count <= count - CntOne;
        default: count <= count;
      endcase
    end
  end

  assign cntZero = (count == '0);
  assign cntFull = (count == CntMax);
endmodule

// File: rtl/mfence_ctl.sv
module mfence_ctl
  import mfence_pkg::*;
(
  input  logic       reqValid,
  input  logic       reqFence,
  input  logic       cmplPulse,
  input  logic       cntZero,
  input  logic       cntFull,
  output logic       issueGrant,
  output logic       stall,
  output ctrStrobe_t stb
);
  logic dataOk;
  logic fenceOk;

  always_comb begin
    dataOk     = reqValid && !reqFence && !cntFull;
    fenceOk    = reqValid && reqFence && cntZero;
    issueGrant = dataOk || fenceOk;
    stall      = reqValid && !issueGrant;
    stb.incr   = dataOk;
    stb.decr   = cmplPulse && !cntZero;
  end
endmodule

// File: rtl/fence_tracker.sv
module fence_tracker
  import mfence_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqFence,
  input  logic cmplPulse,
  output logic issueGrant,
  output logic stall
);
  ctrStrobe_t       ctrStb;
  logic [CNT_W-1:0] inFlight;
  logic             cntZero;
  logic             cntFull;

  mfence_ctl u_ctl (
    .reqValid  (reqValid),
    .reqFence  (reqFence),
    .cmplPulse (cmplPulse),
    .cntZero   (cntZero),
    .cntFull   (cntFull),
    .issueGrant(issueGrant),
    .stall     (stall),
    .stb       (ctrStb)
  );

  mfence_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (ctrStb),
    .count  (inFlight),
    .cntZero(cntZero),
    .cntFull(cntFull)
  );
endmodule

// File: rtl/fence_tracker_chk.sv
module fence_tracker_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqFence,
  input logic             cmplPulse,
  input logic             issueGrant,
  input logic             stall,
  input logic [CNT_W-1:0] inFlight
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CntOne = {{(CNT_W-1){1'b0}}, 1'b1};

  logic dataGo;
  assign dataGo = issueGrant && reqValid && !reqFence;

  p_incr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataGo && !cmplPulse) |=> (inFlight == $past(inFlight) + CntOne));

  p_decr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!dataGo && cmplPulse) |=> (inFlight == $past(inFlight) - CntOne));

  p_cmpl_outstanding_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmplPulse |-> (inFlight != '0));

  p_fence_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFence && inFlight != '0) |-> (stall && !issueGrant));

  p_fence_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqFence && inFlight == '0) |-> issueGrant);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (reqValid && !issueGrant));

  p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataGo && cmplPulse) |=> $stable(inFlight));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight == CntMax && reqValid && !reqFence) |-> !issueGrant);
endmodule

bind fence_tracker fence_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqFence  (reqFence),
  .cmplPulse (cmplPulse),
  .issueGrant(issueGrant),
  .stall     (stall),
  .inFlight  (inFlight)
);

// File: tb/test_fence_tracker.sv
`timescale 1ns/100ps
module test_fence_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqFence = 1'b0;
  logic cmplPulse = 1'b0;
  logic issueGrant;
  logic stall;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fence_tracker #(.CNT_W(2)) i_fence_tracker (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFence  (reqFence),
    .cmplPulse (cmplPulse),
    .issueGrant(issueGrant),
    .stall     (stall)
  );

  // Drive one cycle of inputs at the falling edge, then check the outputs
  // before the next rising edge.
  task automatic cyc(input logic v, input logic f, input logic c,
                     input logic expG, input logic expS, input string tag);
    @(negedge clk);
    reqValid  = v;
    reqFence  = f;
    cmplPulse = c;
    #0.5;
    nRun++;
    if (issueGrant !== expG || stall !== expS) begin
      nFail++;
      $display("FAIL %s: grant=%b stall=%b expected grant=%b stall=%b",
               tag, issueGrant, stall, expG, expS);
    end
  endtask

  task automatic t_reset();
    cyc(0, 0, 0, 0, 0, "R1 idle after reset");
    cyc(1, 1, 0, 1, 0, "R1 fence granted at zero after reset");
  endtask

  task automatic t_fence_wait();
    cyc(1, 0, 0, 1, 0, "R2 data issue 1");
    cyc(1, 0, 0, 1, 0, "R2 data issue 2");
    cyc(1, 0, 0, 1, 0, "R2 data issue 3");
    cyc(1, 1, 1, 0, 1, "R4 fence held count 3");
    cyc(1, 1, 1, 0, 1, "R4 R3 fence held count 2");
    cyc(1, 1, 1, 0, 1, "R6 fence held count 1, nothing issues");
    cyc(1, 1, 0, 1, 0, "R5 fence granted first zero cycle");
    cyc(1, 0, 0, 1, 0, "R6 data after fence issues next cycle");
    cyc(0, 0, 1, 0, 0, "R3 drain");
    cyc(1, 1, 0, 1, 0, "R3 fence confirms drained");
  endtask

  task automatic t_same_cycle();
    cyc(1, 0, 0, 1, 0, "R2 issue to count 1");
    cyc(1, 0, 1, 1, 0, "R7 issue with completion");
    cyc(1, 1, 0, 0, 1, "R7 fence held, count still 1");
    cyc(1, 1, 1, 0, 1, "R7 fence held during last completion");
    cyc(1, 1, 0, 1, 0, "R7 fence granted after exactly one completion");
  endtask

  task automatic t_saturate();
    cyc(1, 0, 0, 1, 0, "R2 fill 1");
    cyc(1, 0, 0, 1, 0, "R2 fill 2");
    cyc(1, 0, 0, 1, 0, "R2 fill 3");
    cyc(1, 0, 0, 0, 1, "R8 full data stalls");
    cyc(1, 0, 1, 0, 1, "R8 still full while completion lands");
    cyc(1, 0, 0, 1, 0, "R8 data granted after one completion");
    cyc(1, 0, 0, 0, 1, "R8 full again, no wrap");
    cyc(1, 1, 1, 0, 1, "R8 fence held at 3");
    cyc(1, 1, 1, 0, 1, "R8 fence held at 2");
    cyc(1, 1, 1, 0, 1, "R8 fence held at 1");
    cyc(1, 1, 0, 1, 0, "R8 fence granted after three completions");
  endtask

  task automatic t_fence_pair();
    cyc(1, 1, 0, 1, 0, "R9 first fence");
    cyc(1, 1, 0, 1, 0, "R9 second fence");
    cyc(1, 0, 0, 1, 0, "R9 data after fences");
    cyc(1, 1, 0, 0, 1, "R9 fence behind data held");
    cyc(1, 1, 1, 0, 1, "R9 fence held during completion");
    cyc(1, 1, 0, 1, 0, "R9 fence retires");
    cyc(1, 1, 0, 1, 0, "R9 next fence retires in order");
    cyc(0, 0, 0, 0, 0, "R1 idle end");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fence_wait();
    t_same_cycle();
    t_saturate();
    t_fence_pair();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule